// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block drives the control signals of a multicycle datapath from a small hard-coded microprogram rather than from a hand-built next-state function. A microaddress register selects one of ten control words. Each word holds six encoded fields that select the datapath control signals and a 2-bit sequencing field. Each field sets its own group of signals, and no two fields drive the same signal. The microaddress of a step is the number of the matching state in the equivalent state machine, so the sequencer's outputs match that machine cycle for cycle.

The steps are named by microaddress: FETCH (0), DECODE (1), MEM_ADDR (2), MEM_READ (3), LOAD_WB (4), MEM_WRITE (5), EXEC (6), RTYPE_WB (7), BRANCH (8) and JUMP (9). The sequencing field chooses the next microaddress, encoded as 00 = FETCH, 01 = first dispatch, 10 = second dispatch and 11 = next (microaddress + 1). The transitions are FETCH->DECODE, DECODE->dispatch 1, MEM_ADDR->dispatch 2, MEM_READ->LOAD_WB and EXEC->RTYPE_WB. LOAD_WB, MEM_WRITE, RTYPE_WB, BRANCH and JUMP each return to FETCH. The two dispatch tables are indexed by the 6-bit opcode.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_n is low the microaddress is FETCH, and the outputs hold the FETCH control values of R2. Reset is asynchronous.
- R2: In FETCH the asserted outputs are mem_rd, ir_wr and pc_wr, with alu_src_b=01, and every other output is 0. In DECODE the only non-zero output is alu_src_b=11. FETCH is always followed by DECODE.
- R3: From DECODE the next step is chosen by opcode: 0x00 (register-register) goes to EXEC, 0x02 (jump) to JUMP, 0x04 (branch if equal) to BRANCH, and 0x23 (load) or 0x2B (store) to MEM_ADDR.
- R4: From MEM_ADDR, opcode 0x23 goes to MEM_READ and opcode 0x2B goes to MEM_WRITE. Any other opcode seen on that edge goes to FETCH.
- R5: An opcode that has no entry in the DECODE dispatch table sends DECODE back to FETCH.
- R6: The steps FETCH, MEM_READ and EXEC are each followed by the next microaddress in order, whatever the opcode.
- R7: LOAD_WB, MEM_WRITE, RTYPE_WB, BRANCH and JUMP are each followed by FETCH.
- R8: The memory and write-back steps give these outputs, with all others 0. MEM_READ gives mem_rd=1 and iord=1. MEM_WRITE gives mem_wr=1 and iord=1. LOAD_WB gives reg_wr=1 and mem_to_reg=1. RTYPE_WB gives reg_wr=1 and reg_dst=1.
- R9: The ALU steps give these outputs, with all others 0. MEM_ADDR gives alu_src_a=1 and alu_src_b=10. EXEC gives alu_src_a=1 and alu_op=10. BRANCH gives alu_src_a=1, alu_op=01, pc_wr_cond=1 and pc_src=01.
- R10: JUMP gives pc_wr=1 and pc_src=10, with all other outputs 0.
- R11: The outputs depend only on the registered microaddress. A change of opcode between clock edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode of the current instruction |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write if the ALU result is zero |
| iord | output | 1 | Memory address from the ALU result (1) or the program counter (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data from memory data (1) or the ALU result (0) |
| pc_src | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function code |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU operand B: 00 B, 01 constant 4, 10 immediate, 11 shifted immediate |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register field: 1 rd, 0 rt |

## Verification
Each control word appears in the cycle after the rising edge that loads its microaddress. No other register lies between the opcode and the outputs, so the successor chosen from an opcode is visible half a period after the edge at which that opcode was presented. The bench drives the opcode at the falling edge, advances a behavioural step model at the rising edge, and compares all sixteen output bits at the next falling edge. For R11 it then flips the opcode in the low half-period and compares again before the next rising edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int OP_W     = 6;
    localparam int UA_W     = 4;
    localparam int CS_DEPTH = 10;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    typedef enum logic [UA_W-1:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_MEM_READ  = 4'd3,
        ST_LOAD_WB   = 4'd4,
        ST_MEM_WRITE = 4'd5,
        ST_EXEC      = 4'd6,
        ST_RTYPE_WB  = 4'd7,
        ST_BRANCH    = 4'd8,
        ST_JUMP      = 4'd9
    } uaddr_e;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_DISP1 = 2'b01,
        SQ_DISP2 = 2'b10,
        SQ_NEXT  = 2'b11
    } seq_e;

    typedef enum logic [1:0] { AC_NONE, AC_ADD, AC_SUB, AC_FUNC } aluc_e;
    typedef enum logic       { S1_PC, S1_A } src1_e;
    typedef enum logic [1:0] { S2_B = 2'b00, S2_FOUR = 2'b01, S2_EXT = 2'b10, S2_EXTSH = 2'b11 } src2_e;
    typedef enum logic [1:0] { RC_NONE, RC_WR_ALU, RC_WR_MDR } regc_e;
    typedef enum logic [1:0] { MC_NONE, MC_RD_PC, MC_RD_ALU, MC_WR_ALU } memc_e;
    typedef enum logic [1:0] { PW_NONE, PW_ALU, PW_COND, PW_JADDR } pcw_e;

    typedef struct packed {
        aluc_e alu;
        src1_e s1;
        src2_e s2;
        regc_e rc;
        memc_e mc;
        pcw_e  pw;
        seq_e  sq;
    } uinstr_t;
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_e  addr,
    output uinstr_t word
);
    always_comb begin
        unique case (addr)
            ST_FETCH:     word = '{AC_ADD,  S1_PC, S2_FOUR,  RC_NONE,   MC_RD_PC,  PW_ALU,   SQ_NEXT};
            ST_DECODE:    word = '{AC_ADD,  S1_PC, S2_EXTSH, RC_NONE,   MC_NONE,   PW_NONE,  SQ_DISP1};
            ST_MEM_ADDR:  word = '{AC_ADD,  S1_A,  S2_EXT,   RC_NONE,   MC_NONE,   PW_NONE,  SQ_DISP2};
            ST_MEM_READ:  word = '{AC_NONE, S1_PC, S2_B,     RC_NONE,   MC_RD_ALU, PW_NONE,  SQ_NEXT};
            ST_LOAD_WB:   word = '{AC_NONE, S1_PC, S2_B,     RC_WR_MDR, MC_NONE,   PW_NONE,  SQ_FETCH};
            ST_MEM_WRITE: word = '{AC_NONE, S1_PC, S2_B,     RC_NONE,   MC_WR_ALU, PW_NONE,  SQ_FETCH};
            ST_EXEC:      word = '{AC_FUNC, S1_A,  S2_B,     RC_NONE,   MC_NONE,   PW_NONE,  SQ_NEXT};
            ST_RTYPE_WB:  word = '{AC_NONE, S1_PC, S2_B,     RC_WR_ALU, MC_NONE,   PW_NONE,  SQ_FETCH};
            ST_BRANCH:    word = '{AC_SUB,  S1_A,  S2_B,     RC_NONE,   MC_NONE,   PW_COND,  SQ_FETCH};
            ST_JUMP:      word = '{AC_NONE, S1_PC, S2_B,     RC_NONE,   MC_NONE,   PW_JADDR, SQ_FETCH};
            default:      word = '{AC_NONE, S1_PC, S2_B,     RC_NONE,   MC_NONE,   PW_NONE,  SQ_FETCH};
        endcase
    end
endmodule

// File: rtl/useq_field_dec.sv
module useq_field_dec
    import useq_pkg::*;
(
    input  aluc_e      alu,
    input  src1_e      s1,
    input  src2_e      s2,
    input  regc_e      rc,
    input  memc_e      mc,
    input  pcw_e       pw,
    output logic       pc_wr,
    output logic       pc_wr_cond,
    output logic [1:0] pc_src,
    output logic       iord,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       ir_wr,
    output logic       mem_to_reg,
    output logic       reg_wr,
    output logic       reg_dst,
    output logic [1:0] alu_op,
    output logic       alu_src_a,
    output logic [1:0] alu_src_b
);
    always_comb begin
        unique case (alu)
            AC_SUB:  alu_op = 2'b01;
            AC_FUNC: alu_op = 2'b10;
            default: alu_op = 2'b00;
        endcase
        alu_src_a = (s1 == S1_A);
        alu_src_b = s2;
    end

    always_comb begin
        reg_wr = 1'b0; reg_dst = 1'b0; mem_to_reg = 1'b0;
        unique case (rc)
            RC_WR_ALU: begin reg_wr = 1'b1; reg_dst = 1'b1; end
            RC_WR_MDR: begin reg_wr = 1'b1; mem_to_reg = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        mem_rd = 1'b0; mem_wr = 1'b0; iord = 1'b0; ir_wr = 1'b0;
        unique case (mc)
            MC_RD_PC:  begin mem_rd = 1'b1; ir_wr = 1'b1; end
            MC_RD_ALU: begin mem_rd = 1'b1; iord = 1'b1; end
            MC_WR_ALU: begin mem_wr = 1'b1; iord = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        pc_wr = 1'b0; pc_wr_cond = 1'b0; pc_src = 2'b00;
        unique case (pw)
            PW_ALU:   pc_wr = 1'b1;
            PW_COND:  begin pc_wr_cond = 1'b1; pc_src = 2'b01; end
            PW_JADDR: begin pc_wr = 1'b1; pc_src = 2'b10; end
            default: ;
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLE = 1
) (
    input  logic [OP_W-1:0] op,
    output uaddr_e          target
);
    generate
        if (TABLE == 1) begin : g_decode_table
            always_comb begin
                unique case (op)
                    OPC_RTYPE:          target = ST_EXEC;
                    OPC_JUMP:           target = ST_JUMP;
                    OPC_BEQ:            target = ST_BRANCH;
                    OPC_LOAD, OPC_STORE: target = ST_MEM_ADDR;
                    default:            target = ST_FETCH;
                endcase
            end
        end else begin : g_memory_table
            always_comb begin
                unique case (op)
                    OPC_LOAD:  target = ST_MEM_READ;
                    OPC_STORE: target = ST_MEM_WRITE;
                    default:   target = ST_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/useq_addr_sel.sv
module useq_addr_sel
    import useq_pkg::*;
(
    input  seq_e   sq,
    input  uaddr_e cur,
    input  uaddr_e disp1,
    input  uaddr_e disp2,
    output uaddr_e nxt
);
    logic [UA_W-1:0] incr;

    assign incr = cur + {{(UA_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (sq)
            SQ_DISP1: nxt = disp1;
            SQ_DISP2: nxt = disp2;
            SQ_NEXT:  nxt = uaddr_e'(incr);
            default:  nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            iord,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            mem_to_reg,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_op,
    output logic            alu_src_a,
    output logic [1:0]      alu_src_b,
    output logic            reg_wr,
    output logic            reg_dst
);
    uaddr_e  upc_q, upc_d, disp1_tgt, disp2_tgt;
    uinstr_t uword;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upc_q <= ST_FETCH;
        else        upc_q <= upc_d;
    end

    useq_store u_store (.addr(upc_q), .word(uword));

    useq_dispatch #(.TABLE(1)) u_disp1 (.op(opcode), .target(disp1_tgt));
    useq_dispatch #(.TABLE(2)) u_disp2 (.op(opcode), .target(disp2_tgt));

    useq_addr_sel u_sel (
        .sq(uword.sq), .cur(upc_q), .disp1(disp1_tgt), .disp2(disp2_tgt), .nxt(upc_d)
    );

    useq_field_dec u_dec (
        .alu(uword.alu), .s1(uword.s1), .s2(uword.s2), .rc(uword.rc),
        .mc(uword.mc), .pw(uword.pw),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .iord(iord),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .mem_to_reg(mem_to_reg),
        .reg_wr(reg_wr), .reg_dst(reg_dst), .alu_op(alu_op),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b)
    );

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        upc_q == ST_FETCH |=> upc_q == ST_DECODE); // R2
    AST_DECODE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == ST_DECODE && opcode == OPC_JUMP) |=> upc_q == ST_JUMP); // R3
    AST_MADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == ST_MEM_ADDR && opcode == OPC_LOAD) |=> upc_q == ST_MEM_READ); // R4
    AST_SEQ_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        upc_q == ST_EXEC |=> upc_q == ST_RTYPE_WB); // R6
    AST_END_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q inside {ST_LOAD_WB, ST_MEM_WRITE, ST_RTYPE_WB, ST_BRANCH, ST_JUMP})
        |=> upc_q == ST_FETCH); // R7
    AST_MEM_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8
    AST_UPC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(upc_q) < CS_DEPTH); // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(upc_q) |-> $stable({pc_wr, mem_rd, mem_wr, reg_wr, alu_op})); // R11
endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg;
    logic [1:0] pc_src, alu_op, alu_src_b;
    logic       alu_src_a, reg_wr, reg_dst;

    int total = 0;
    int bad = 0;
    int ref_state = 0;
    bit done = 0;

    always #2 clk = ~clk;

    useq_sequencer dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .iord(iord), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ir_wr(ir_wr), .mem_to_reg(mem_to_reg), .pc_src(pc_src),
        .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .reg_wr(reg_wr), .reg_dst(reg_dst)
    );

    // packing: pc_wr,pc_wr_cond,iord,mem_rd,mem_wr,ir_wr,mem_to_reg,pc_src,alu_op,alu_src_a,alu_src_b,reg_wr,reg_dst
    function automatic logic [15:0] observed();
        return {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg,
                pc_src, alu_op, alu_src_a, alu_src_b, reg_wr, reg_dst};
    endfunction

    function automatic logic [15:0] ref_ctl(int s);
        logic pw = 0, pwc = 0, io = 0, mr = 0, mw = 0, ir = 0, m2r = 0, sa = 0, rw = 0, rd = 0;
        logic [1:0] ps = 0, ao = 0, sb = 0;
        case (s)
            0: begin mr = 1; ir = 1; pw = 1; sb = 2'b01; end
            1: sb = 2'b11;
            2: begin sa = 1; sb = 2'b10; end
            3: begin mr = 1; io = 1; end
            4: begin rw = 1; m2r = 1; end
            5: begin mw = 1; io = 1; end
            6: begin sa = 1; ao = 2'b10; end
            7: begin rw = 1; rd = 1; end
            8: begin sa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
            9: begin pw = 1; ps = 2'b10; end
            default: ;
        endcase
        return {pw, pwc, io, mr, mw, ir, m2r, ps, ao, sa, sb, rw, rd};
    endfunction

    function automatic int ref_next(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: case (op)
                   6'h00: return 6;
                   6'h02: return 9;
                   6'h04: return 8;
                   6'h23, 6'h2B: return 2;
                   default: return 0;
               endcase
            2: return (op == 6'h23) ? 3 : (op == 6'h2B) ? 5 : 0;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(int prev, int now, logic [5:0] op);
        string t, u;
        if (prev == 1) t = (now == 0 && !(op inside {6'h00, 6'h02, 6'h04, 6'h23, 6'h2B})) ? "R5" : "R3";
        else if (prev == 2) t = "R4";
        else if (prev == 0 || prev == 3 || prev == 6) t = "R6";
        else t = "R7";
        if (now <= 1) u = "R2";
        else if (now == 9) u = "R10";
        else if (now == 2 || now == 6 || now == 8) u = "R9";
        else u = "R8";
        return {t, "/", u};
    endfunction

    task automatic check(string req, logic [15:0] exp);
        total++;
        if (observed() !== exp) begin
            bad++;
            $display("FAIL %s state=%0d actual=%b expected=%b", req, ref_state, observed(), exp);
        end
    endtask

    task automatic step(logic [5:0] op);
        int prev;
        opcode = op;
        @(posedge clk);
        prev = ref_state;
        ref_state = ref_next(ref_state, op);
        @(negedge clk);
        check(tag_for(prev, ref_state, op), ref_ctl(ref_state));
        opcode = op ^ 6'h3F;
        #0.5;
        check("R11", ref_ctl(ref_state));
    endtask

    task automatic run_instr(logic [5:0] op);
        do step(op); while (ref_state != 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", ref_ctl(0));
        rst_n = 1'b1;
        run_instr(6'h00);
        run_instr(6'h23);
        run_instr(6'h2B);
        run_instr(6'h04);
        run_instr(6'h02);
        run_instr(6'h3F);
        run_instr(6'h08);
        run_instr(6'h23);
        run_instr(6'h00);
        run_instr(6'h02);
        // dispatch 2 seeing a non-memory opcode
        step(6'h23); step(6'h23); step(6'h04);
        run_instr(6'h2B);
        // asynchronous reset in the middle of an instruction
        step(6'h00); step(6'h00); step(6'h00);
        #0.5 rst_n = 1'b0;
        #0.5;
        ref_state = 0;
        check("R1", ref_ctl(0));
        @(negedge clk);
        rst_n = 1'b1;
        run_instr(6'h04);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule